// File: doc/BRIEF.md
# Selectable Fall-Through Synchronous FIFO

This block is a single-clock 36-bit FIFO with an output register placed after its storage array. A mode bit, captured while reset is held, selects how that register is filled. In fall-through mode, a word written into an empty FIFO goes straight to the output register, and an output-ready flag rises on that same edge. In standard mode, the output register is loaded only by an explicit read, and the flag means that the memory is not empty.

Each port has four qualifiers: an active-low chip select, a direction select, an enable and a mailbox select. A transfer happens only when all four take their transfer values. The word in the output register is not counted as stored. The full/input-ready, almost-empty and almost-full flags all follow the memory count alone. The almost-empty and almost-full thresholds are offsets captured during reset. The read data bus comes with an output-enable that stands for the tri-state control.

Top module: `fwft_sel_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it: memory count 0, `rd_flag` low, `wr_flag` high, `ae_n` low, `af_n` high and `rd_data` all zeros.
- R2: A write is accepted on a rising edge only when `wr_cs_n`=0, `wr_dir`=1, `wr_en`=1 and `wr_mbx`=0. Every other combination of these four stores nothing.
- R3: A read is performed on a rising edge only when `rd_cs_n`=0, `rd_dir`=1, `rd_en`=1, `rd_mbx`=0 and `rd_flag`=1. Every other combination leaves the output register and the count unchanged.
- R4: In standard mode (`cfg_fwft`=0), `rd_data` changes only on a performed read, which loads the oldest stored word. `rd_flag` is 1 exactly when the memory count is nonzero.
- R5: In fall-through mode with `rd_flag`=0, an accepted write puts its word on `rd_data` at the same edge. `rd_flag` rises on that edge and the memory count stays 0.
- R6: In fall-through mode with `rd_flag`=1, a read loads the oldest stored word. If no word is stored (and none is written in that cycle), `rd_flag` falls and `rd_data` keeps its value.
- R7: The output register is not counted. `wr_flag` is 0 exactly when the memory holds DEPTH words. Fall-through mode therefore accepts DEPTH+1 writes from empty, and standard mode accepts DEPTH.
- R8: `ae_n` is 0 exactly when the memory count is at most the almost-empty offset.
- R9: `af_n` is 0 exactly when the memory count is at least DEPTH minus the almost-full offset.
- R10: A write while `wr_flag`=0 or a read while `rd_flag`=0 changes neither the stored contents nor the count.
- R11: `rd_oe` equals the inverse of `rd_cs_n` in every cycle.
- R12: `cfg_fwft`, `cfg_ae_off` and `cfg_af_off` are captured only while `rst` is high. Changes made after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset, also captures the configuration |
| cfg_fwft | input | 1 | 1 selects fall-through mode, 0 selects standard mode |
| cfg_ae_off | input | AW+1 | Almost-empty offset |
| cfg_af_off | input | AW+1 | Almost-full offset |
| wr_cs_n | input | 1 | Write-port chip select, active low |
| wr_dir | input | 1 | Write-port direction, 1 = write |
| wr_en | input | 1 | Write-port enable |
| wr_mbx | input | 1 | Write-port mailbox select, must be 0 for a FIFO write |
| wr_data | input | DW | Write word |
| rd_cs_n | input | 1 | Read-port chip select, active low |
| rd_dir | input | 1 | Read-port direction, 1 = read |
| rd_en | input | 1 | Read-port enable |
| rd_mbx | input | 1 | Read-port mailbox select, must be 0 for a FIFO read |
| rd_data | output | DW | Output register |
| rd_oe | output | 1 | Output enable for the read data bus |
| rd_flag | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active high |
| wr_flag | output | 1 | Full/input-ready flag, 1 = room available |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
Each of the eight combinations of mode and two offset pairs goes through the same program of stimulus patterns, each aimed at a different behaviour:
- Fill past capacity, then drain past empty. This shows where the full flag and the threshold flags switch, and whether the output register was counted (one extra word is accepted only in fall-through mode).
- Sweep all sixteen qualifier combinations on each port. This separates a true transfer from a mailbox, disabled or deselected cycle.
- Run a pseudo-random stretch of simultaneous reads and writes. This exercises the edge where a read empties the output register while a write refills it, and the cycle where both happen on an empty memory.
- Change the configuration inputs after reset. This shows that they were captured only during reset.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;
  // Arithmetic shared by the level tracker; the bench restates it independently.
  function automatic logic near_empty(input int unsigned cnt, input int unsigned off);
    return cnt <= off;
  endfunction

  function automatic logic near_full(input int unsigned cnt, input int unsigned off,
                                     input int unsigned depth);
    return (cnt + off) >= depth;
  endfunction
endpackage

// File: rtl/fwft_store.sv
module fwft_store #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] head_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk) begin
    if (push) cells[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  assign head_data = cells[rptr_q];

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    pop |=> rptr_q == $past(rptr_q) + 1'b1); // R4
endmodule

// File: rtl/fwft_level.sv
module fwft_level #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic        pop,
  input  logic [AW:0] ae_off,
  input  logic [AW:0] af_off,
  output logic [AW:0] count,
  output logic        mem_empty,
  output logic        mem_full,
  output logic        ae_n,
  output logic        af_n
);
  import fwft_fifo_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [AW:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (push && !pop) cnt_q <= cnt_q + 1'b1;
    else if (pop && !push) cnt_q <= cnt_q - 1'b1;
  end

  assign count     = cnt_q;
  assign mem_empty = (cnt_q == '0);
  assign mem_full  = (cnt_q == DEPTH_C);
  assign ae_n      = !near_empty(int'(cnt_q), int'(ae_off));
  assign af_n      = !near_full(int'(cnt_q), int'(af_off), DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DEPTH_C); // R7
  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> cnt_q == (AW+1)'($past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/fwft_out_stage.sv
module fwft_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          consume,
  output logic [DW-1:0] dout,
  output logic          ready
);
  logic [DW-1:0] dout_q;
  logic          ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      if (load) dout_q <= load_data;
      if (load)         ready_q <= 1'b1;
      else if (consume) ready_q <= 1'b0;
    end
  end

  assign dout  = dout_q;
  assign ready = ready_q;

  AST_LOAD_READY: assert property (@(posedge clk) disable iff (rst)
    load |=> ready_q && dout_q == $past(load_data)); // R5
endmodule

// File: rtl/fwft_sel_fifo.sv
module fwft_sel_fifo #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_fwft,
  input  logic [AW:0]   cfg_ae_off,
  input  logic [AW:0]   cfg_af_off,
  input  logic          wr_cs_n,
  input  logic          wr_dir,
  input  logic          wr_en,
  input  logic          wr_mbx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_cs_n,
  input  logic          rd_dir,
  input  logic          rd_en,
  input  logic          rd_mbx,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          ae_n,
  output logic          af_n
);
  // Configuration captured during reset
  logic          mode_fwft_q;
  logic [AW:0]   ae_off_q, af_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_fwft_q <= cfg_fwft;
      ae_off_q    <= cfg_ae_off;
      af_off_q    <= cfg_af_off;
    end
  end

  // Named events
  logic wr_sel, rd_sel, wr_fire, rd_fire, push, pop, bypass, load;
  logic mem_empty, mem_full, out_ready;
  logic [AW:0]   count;
  logic [DW-1:0] head_data, load_data;

  assign wr_sel  = !wr_cs_n && wr_dir && wr_en && !wr_mbx;
  assign rd_sel  = !rd_cs_n && rd_dir && rd_en && !rd_mbx;
  assign wr_fire = wr_sel && !mem_full;
  assign rd_fire = rd_sel && rd_flag;
  assign pop     = rd_fire && !mem_empty;
  assign bypass  = mode_fwft_q && wr_fire && mem_empty && (!out_ready || rd_fire);
  assign push    = wr_fire && !bypass;
  assign load    = pop || bypass;
  assign load_data = bypass ? wr_data : head_data;

  fwft_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_data(wr_data), .head_data(head_data)
  );

  fwft_level #(.AW(AW)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .ae_off(ae_off_q), .af_off(af_off_q), .count(count),
    .mem_empty(mem_empty), .mem_full(mem_full), .ae_n(ae_n), .af_n(af_n)
  );

  fwft_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .consume(rd_fire && mode_fwft_q), .dout(rd_data), .ready(out_ready)
  );

  assign rd_flag = mode_fwft_q ? out_ready : !mem_empty;
  assign wr_flag = !mem_full;
  assign rd_oe   = !rd_cs_n;

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (mode_fwft_q && wr_fire && !rd_flag) |=> rd_flag && rd_data == $past(wr_data)); // R5
  AST_STD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mode_fwft_q && !rd_fire) |=> $stable(rd_data)); // R4
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && !rd_flag && !wr_sel) |=> $stable(rd_data) && $stable(count)); // R10
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && !wr_flag && !rd_sel) |=> $stable(count)); // R10
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_fwft_q) && $stable(ae_off_q) && $stable(af_off_q)); // R12
endmodule

// File: tb/tb_fwft_sel_fifo.sv
module tb_fwft_sel_fifo;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fwft = 1'b0;
  logic [AW:0] cfg_ae_off = '0, cfg_af_off = '0;
  logic wr_cs_n = 1'b1, wr_dir = 1'b0, wr_en = 1'b0, wr_mbx = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_cs_n = 1'b1, rd_dir = 1'b0, rd_en = 1'b0, rd_mbx = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_oe, rd_flag, wr_flag, ae_n, af_n;

  always #2 clk = ~clk;

  fwft_sel_fifo #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .cfg_fwft(cfg_fwft), .cfg_ae_off(cfg_ae_off),
    .cfg_af_off(cfg_af_off), .wr_cs_n(wr_cs_n), .wr_dir(wr_dir), .wr_en(wr_en),
    .wr_mbx(wr_mbx), .wr_data(wr_data), .rd_cs_n(rd_cs_n), .rd_dir(rd_dir),
    .rd_en(rd_en), .rd_mbx(rd_mbx), .rd_data(rd_data), .rd_oe(rd_oe),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .ae_n(ae_n), .af_n(af_n)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [DW-1:0] q[$];
  logic [DW-1:0] m_out;
  logic m_ready, m_fwft;
  int m_x, m_y;
  int seq = 0;

  task automatic chk(input bit ok, input string tag, input string sig,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, sig, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic e_flag;
    int n;
    n = q.size();
    e_flag = m_fwft ? m_ready : (n > 0);
    chk(rd_data === m_out, tag, "rd_data", rd_data, m_out);
    chk(rd_flag === e_flag, {tag, " R4/R6"}, "rd_flag", 36'(rd_flag), 36'(e_flag));
    chk(wr_flag === (n != D), {tag, " R7"}, "wr_flag", 36'(wr_flag), 36'(n != D));
    chk(ae_n === !(n <= m_x), {tag, " R8"}, "ae_n", 36'(ae_n), 36'(!(n <= m_x)));
    chk(af_n === !(n >= D - m_y), {tag, " R9"}, "af_n", 36'(af_n), 36'(!(n >= D - m_y)));
    chk(rd_oe === !rd_cs_n, {tag, " R11"}, "rd_oe", 36'(rd_oe), 36'(!rd_cs_n));
  endtask

  task automatic cyc(input logic wcs, input logic wdr, input logic wen, input logic wmb,
                     input logic rcs, input logic rdr, input logic ren, input logic rmb,
                     input string tag);
    bit w_sel, r_sel, w_ok, r_ok;
    logic [DW-1:0] wd;
    int n;
    seq++;
    wd = {4'hA, 32'(seq * 7 + 3)};
    wr_cs_n = wcs; wr_dir = wdr; wr_en = wen; wr_mbx = wmb; wr_data = wd;
    rd_cs_n = rcs; rd_dir = rdr; rd_en = ren; rd_mbx = rmb;
    w_sel = !wcs && wdr && wen && !wmb;
    r_sel = !rcs && rdr && ren && !rmb;
    n = q.size();
    w_ok = w_sel && (n < D);
    r_ok = r_sel && (m_fwft ? m_ready : (n > 0));
    @(posedge clk);
    if (m_fwft) begin
      if (r_ok) begin
        if (n > 0) m_out = q.pop_front();
        else m_ready = 1'b0;
      end
      if (w_ok) begin
        if (n == 0 && !m_ready) begin m_out = wd; m_ready = 1'b1; end
        else q.push_back(wd);
      end
    end else begin
      if (r_ok) m_out = q.pop_front();
      if (w_ok) q.push_back(wd);
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input string tag); cyc(0,1,1,0, 1,0,0,0, tag); endtask
  task automatic rd(input string tag); cyc(1,0,0,0, 0,1,1,0, tag); endtask

  task automatic do_reset(input logic f, input int x, input int y);
    @(negedge clk);
    rst = 1'b1; cfg_fwft = f; cfg_ae_off = (AW+1)'(x); cfg_af_off = (AW+1)'(y);
    wr_cs_n = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b1; rd_en = 1'b0;
    @(posedge clk); @(negedge clk);
    q.delete(); m_out = '0; m_ready = 1'b0; m_fwft = f; m_x = x; m_y = y;
    compare("R1 in reset");
    rst = 1'b0;
    // Disturb the configuration inputs: must be ignored (R12)
    cfg_fwft = !f; cfg_ae_off = '0; cfg_af_off = '0;
    @(posedge clk); @(negedge clk);
    compare("R1 after reset R12");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int f = 0; f < 2; f++) begin
      for (int xi = 0; xi < 2; xi++) begin
        for (int yi = 0; yi < 2; yi++) begin
          do_reset(f[0], xi ? 3 : 1, yi ? 4 : 2);
          wr(f ? "R5 first word" : "R4 first write");
          repeat (D + 2) wr("R7 fill past full R10");
          repeat (D + 3) rd(f ? "R6 drain" : "R4 drain R10");
          // Write-port qualifier sweep, read idle
          for (int p = 0; p < 16; p++)
            cyc(p[3], p[2], p[1], p[0], 1,0,0,0, "R2 write qualifiers");
          repeat (3) wr("R2 refill");
          // Read-port qualifier sweep, write idle
          for (int p = 0; p < 16; p++)
            cyc(1,0,0,0, p[3], p[2], p[1], p[0], "R3 read qualifiers");
          // Mixed simultaneous traffic
          for (int k = 0; k < 80; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(!lfsr[0], 1, 1, 0, !lfsr[1] && !lfsr[2], 1, 1, 0, "R10 mixed traffic");
          end
          repeat (D + 3) rd("R6 final drain R4");
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule